// File: doc/BRIEF.md
# Transactional Token Conflict Checker

This block decides, at memory-block granularity, whether a transaction may read or write a block. Every block carries a fixed budget of `TOKENS` tokens, and the block stores for each block how many tokens every thread currently holds. A thread that reads a block transactionally must hold at least one token on it. A thread that writes a block must hold the whole budget. A request that needs tokens another thread holds is refused as a conflict.

A request gives a thread id, a block index and a read/write flag, and gets a grant or a conflict answer one cycle later. When a transaction commits or aborts, its thread raises a one-cycle release strobe. A sequencer then zeroes that thread's count in every block, one block per cycle, and raises a per-thread completion flag when it has finished. Pending releases are queued and served in thread order. Undo logging and data versioning are kept elsewhere.

Top module: `tt_conflict_checker`

## Requirements
- R1: After reset every count is zero, `resp_valid_o`, `resp_grant_o` and `resp_conflict_o` are low, and `rel_busy_o` and `rel_done_o` are all zero.
- R2: A read is granted if the requester already holds tokens on the block, in which case its count does not change. It is also granted if the other threads together hold fewer than `TOKENS`, in which case the requester's count becomes 1.
- R3: A write is granted only if no other thread holds a token on the block. The requester's count then becomes `TOKENS`.
- R4: A read is refused with a conflict when other threads hold all `TOKENS` tokens of the block and the requester holds none.
- R5: A write is refused with a conflict when any other thread holds at least one token on the block.
- R6: A refused request changes no count.
- R7: For every block, the sum of the counts over all threads never exceeds `TOKENS`, and each count is 0, 1 or `TOKENS`.
- R8: The response is registered. `resp_valid_o` is high in the cycle after a request, and only then. While it is high, exactly one of `resp_grant_o` and `resp_conflict_o` is high.
- R9: A pulse on `rel_req_i[t]` while the sequencer is idle clears thread t's counts in all blocks, one block per cycle. `rel_done_o[t]` is high for exactly one cycle, `N_BLK+1` clock edges after the edge that samples the pulse. Other threads' counts are unaffected.
- R10: Releases raised together are served one at a time, with the lowest thread first. The next release starts on the edge after the previous one finishes, so with two threads the second completion comes `N_BLK+1` edges after the first.
- R11: A thread that is the only holder on a block, with one token, is granted a write. This upgrades its count to `TOKENS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_thr_i | input | $clog2(N_THR) | Requesting thread |
| req_blk_i | input | $clog2(N_BLK) | Block index |
| req_wr_i | input | 1 | 1 = write (all tokens), 0 = read (one token) |
| resp_valid_o | output | 1 | Response valid, one cycle after the request |
| resp_grant_o | output | 1 | Request granted |
| resp_conflict_o | output | 1 | Request refused |
| rel_req_i | input | N_THR | Per-thread release-all strobe (commit or abort) |
| rel_busy_o | output | N_THR | Thread has a release pending or in progress |
| rel_done_o | output | N_THR | One-cycle release completion flag |

## Verification
The checks assume that a thread issues no request while its own release is pending or running. Under that assumption, a request never meets a clear of the same thread's count in the same cycle. The design includes an assertion that flags any breach of this assumption. The directed stimulus waits for each thread's completion flag before that thread requests again. The only requests made during a release come from other threads.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef struct packed {
    logic valid;
    logic grant;
    logic conflict;
  } resp_t;
endpackage

// File: rtl/tt_grant_eval.sv
module tt_grant_eval #(
  parameter int N_THR  = 4,
  parameter int TOKENS = 4,
  parameter int CW     = 3,
  parameter int TW     = 2
) (
  input  logic [N_THR-1:0][CW-1:0] blk_cnt_i,
  input  logic [TW-1:0]            thr_i,
  input  logic                     wr_i,
  output logic                     grant_o,
  output logic [CW-1:0]            new_cnt_o
);
  localparam int SW = $clog2(N_THR*TOKENS+1);

  logic [SW-1:0] others;
  logic [CW-1:0] mine;

  always_comb begin
    others = '0;
    for (int i = 0; i < N_THR; i++)
      if (i != int'(thr_i)) others = others + SW'(blk_cnt_i[i]);
    mine = blk_cnt_i[thr_i];
  end

  always_comb begin
    grant_o   = 1'b0;
    new_cnt_o = mine;
    if (wr_i) begin
      if (others == '0) begin
        grant_o   = 1'b1;
        new_cnt_o = CW'(TOKENS);
      end
    end else if (mine != '0) begin
      grant_o = 1'b1;
    end else if (others < SW'(TOKENS)) begin
      grant_o   = 1'b1;
      new_cnt_o = CW'(1);
    end
  end
endmodule

// File: rtl/tt_count_array.sv
module tt_count_array #(
  parameter int N_THR = 4,
  parameter int N_BLK = 8,
  parameter int CW    = 3,
  parameter int TW    = 2,
  parameter int BW    = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [BW-1:0]              rd_blk_i,
  output logic [N_THR-1:0][CW-1:0]   rd_cnt_o,
  input  logic                       clr_en_i,
  input  logic [TW-1:0]              clr_thr_i,
  input  logic [BW-1:0]              clr_blk_i,
  input  logic                       upd_en_i,
  input  logic [TW-1:0]              upd_thr_i,
  input  logic [BW-1:0]              upd_blk_i,
  input  logic [CW-1:0]              upd_val_i,
  output logic [N_BLK*N_THR*CW-1:0]  all_o
);
  logic [N_BLK-1:0][N_THR-1:0][CW-1:0] cnt_q;

  // A clear landing on the block being read is seen by the same request.
  always_comb begin
    rd_cnt_o = cnt_q[rd_blk_i];
    if (clr_en_i && clr_blk_i == rd_blk_i) rd_cnt_o[clr_thr_i] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      if (clr_en_i) cnt_q[clr_blk_i][clr_thr_i] <= '0;
      if (upd_en_i) cnt_q[upd_blk_i][upd_thr_i] <= upd_val_i;
    end
  end

  assign all_o = cnt_q;
endmodule

// File: rtl/tt_release_walker.sv
module tt_release_walker #(
  parameter int N_THR = 4,
  parameter int N_BLK = 8,
  parameter int TW    = 2,
  parameter int BW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_THR-1:0] rel_req_i,
  output logic             clr_en_o,
  output logic [TW-1:0]    clr_thr_o,
  output logic [BW-1:0]    clr_blk_o,
  output logic [N_THR-1:0] busy_o,
  output logic [N_THR-1:0] done_o
);
  logic [N_THR-1:0] pend_q, done_q;
  logic             active_q;
  logic [TW-1:0]    thr_q, pick;
  logic [BW-1:0]    cur_q;

  always_comb begin
    pick = '0;
    for (int i = N_THR-1; i >= 0; i--)
      if (pend_q[i]) pick = TW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      done_q   <= '0;
      active_q <= 1'b0;
      thr_q    <= '0;
      cur_q    <= '0;
    end else begin
      logic [N_THR-1:0] pend_n;
      pend_n = pend_q | rel_req_i;
      done_q <= '0;
      if (active_q) begin
        cur_q <= cur_q + BW'(1);
        if (cur_q == BW'(N_BLK-1)) begin
          active_q      <= 1'b0;
          done_q[thr_q] <= 1'b1;
        end
      end else if (|pend_q) begin
        active_q     <= 1'b1;
        thr_q        <= pick;
        cur_q        <= '0;
        pend_n[pick] = rel_req_i[pick];
      end
      pend_q <= pend_n;
    end
  end

  always_comb begin
    busy_o = pend_q;
    if (active_q) busy_o[thr_q] = 1'b1;
  end

  assign clr_en_o  = active_q;
  assign clr_thr_o = thr_q;
  assign clr_blk_o = cur_q;
  assign done_o    = done_q;

  a_r9_done_ends_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o != '0) |-> $past(active_q) && !active_q);
  a_r10_one_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));
endmodule

// File: rtl/tt_conflict_checker.sv
module tt_conflict_checker #(
  parameter int N_THR  = 4,
  parameter int N_BLK  = 8,
  parameter int TOKENS = 4,
  localparam int TW = (N_THR > 1) ? $clog2(N_THR) : 1,
  localparam int BW = (N_BLK > 1) ? $clog2(N_BLK) : 1,
  localparam int CW = $clog2(TOKENS+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [TW-1:0]    req_thr_i,
  input  logic [BW-1:0]    req_blk_i,
  input  logic             req_wr_i,
  output logic             resp_valid_o,
  output logic             resp_grant_o,
  output logic             resp_conflict_o,
  input  logic [N_THR-1:0] rel_req_i,
  output logic [N_THR-1:0] rel_busy_o,
  output logic [N_THR-1:0] rel_done_o
);
  import tt_pkg::*;

  localparam int FW = N_BLK*N_THR*CW;
  localparam int SW = $clog2(N_THR*TOKENS+1);

  logic                     clr_en, grant;
  logic [TW-1:0]            clr_thr;
  logic [BW-1:0]            clr_blk;
  logic [N_THR-1:0][CW-1:0] blk_cnt;
  logic [CW-1:0]            new_cnt;
  logic [FW-1:0]            cnt_flat;
  resp_t                    resp_q;

  tt_release_walker #(.N_THR(N_THR), .N_BLK(N_BLK), .TW(TW), .BW(BW)) u_walk (
    .clk_i, .rst_ni, .rel_req_i,
    .clr_en_o(clr_en), .clr_thr_o(clr_thr), .clr_blk_o(clr_blk),
    .busy_o(rel_busy_o), .done_o(rel_done_o)
  );

  tt_count_array #(.N_THR(N_THR), .N_BLK(N_BLK), .CW(CW), .TW(TW), .BW(BW)) u_cnt (
    .clk_i, .rst_ni,
    .rd_blk_i(req_blk_i), .rd_cnt_o(blk_cnt),
    .clr_en_i(clr_en), .clr_thr_i(clr_thr), .clr_blk_i(clr_blk),
    .upd_en_i(req_valid_i && grant), .upd_thr_i(req_thr_i),
    .upd_blk_i(req_blk_i), .upd_val_i(new_cnt),
    .all_o(cnt_flat)
  );

  tt_grant_eval #(.N_THR(N_THR), .TOKENS(TOKENS), .CW(CW), .TW(TW)) u_eval (
    .blk_cnt_i(blk_cnt), .thr_i(req_thr_i), .wr_i(req_wr_i),
    .grant_o(grant), .new_cnt_o(new_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) resp_q <= '0;
    else resp_q <= '{valid: req_valid_i,
                     grant: req_valid_i && grant,
                     conflict: req_valid_i && !grant};
  end

  assign resp_valid_o    = resp_q.valid;
  assign resp_grant_o    = resp_q.grant;
  assign resp_conflict_o = resp_q.conflict;

  function automatic logic [SW-1:0] blk_sum(input logic [FW-1:0] f, input int b);
    logic [SW-1:0] s;
    s = '0;
    for (int t = 0; t < N_THR; t++) s = s + SW'(f[(b*N_THR+t)*CW +: CW]);
    return s;
  endfunction

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    a_r7_sum_le_tokens: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blk_sum(cnt_flat, b) <= SW'(TOKENS));
    for (genvar t = 0; t < N_THR; t++) begin : g_thr
      a_r7_count_values: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_flat[(b*N_THR+t)*CW +: CW] inside {CW'(0), CW'(1), CW'(TOKENS)});
    end
  end

  a_r6_deny_keeps_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !grant && !clr_en) |=> cnt_flat == $past(cnt_flat));
  a_r8_resp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);
  a_r8_no_stray_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o && !resp_grant_o && !resp_conflict_o);
  a_r8_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (resp_grant_o ^ resp_conflict_o));
  // Input assumption: a releasing thread stays quiet until its done flag (R9).
  a_r9_no_req_while_releasing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> !rel_busy_o[req_thr_i]);
endmodule

// File: tb/sim_tt_conflict_checker.sv
`timescale 1ns/1ps
module sim_tt_conflict_checker;
  localparam int N_THR = 4, N_BLK = 8, TOKENS = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_valid = 1'b0, req_wr = 1'b0;
  logic [1:0] req_thr = '0;
  logic [2:0] req_blk = '0;
  logic [3:0] rel_req = '0;
  logic       resp_valid, resp_grant, resp_conflict;
  logic [3:0] rel_busy, rel_done;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  tt_conflict_checker #(.N_THR(N_THR), .N_BLK(N_BLK), .TOKENS(TOKENS)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_thr_i(req_thr), .req_blk_i(req_blk), .req_wr_i(req_wr),
    .resp_valid_o(resp_valid), .resp_grant_o(resp_grant), .resp_conflict_o(resp_conflict),
    .rel_req_i(rel_req), .rel_busy_o(rel_busy), .rel_done_o(rel_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_req(input int thr, input int blk, input bit wr, input bit exp_g,
                        input string req);
    @(negedge clk);
    req_valid = 1'b1; req_thr = 2'(thr); req_blk = 3'(blk); req_wr = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid && resp_grant == exp_g && resp_conflict == !exp_g, req,
        int'({resp_valid, resp_grant, resp_conflict}), int'({1'b1, exp_g, !exp_g}));
    @(negedge clk);
    chk(!resp_valid, {req, " R8 idle"}, int'(resp_valid), 0);
  endtask

  task automatic release_one(input int t);
    int seen;
    seen = -1;
    @(negedge clk);
    rel_req[t] = 1'b1;
    @(negedge clk);
    rel_req[t] = 1'b0;
    for (int k = 1; k <= N_BLK + 3; k++) begin
      @(negedge clk);
      if (rel_done[t] && seen < 0) seen = k;
      else if (rel_done[t]) seen = 100;
    end
    chk(seen == N_BLK + 1, "R9 done timing", seen, N_BLK + 1);
  endtask

  task automatic t_reset;
    chk(!resp_valid && !resp_grant && !resp_conflict, "R1 resp", int'(resp_valid), 0);
    chk(rel_busy == '0 && rel_done == '0, "R1 release flags", int'(rel_busy), 0);
  endtask

  task automatic t_shared_reads;
    do_req(0, 0, 1'b0, 1'b1, "R2 first read");
    do_req(1, 0, 1'b0, 1'b1, "R2 second read");
    do_req(2, 0, 1'b0, 1'b1, "R2 third read");
    do_req(3, 0, 1'b0, 1'b1, "R2 fourth read");
    do_req(0, 0, 1'b1, 1'b0, "R5 write with readers");
    do_req(0, 0, 1'b0, 1'b1, "R2 reread holds token");
    release_one(1);
    release_one(2);
    release_one(3);
    do_req(0, 0, 1'b1, 1'b1, "R11 upgrade to write");
    do_req(1, 0, 1'b0, 1'b0, "R4 read vs writer");
    do_req(2, 0, 1'b1, 1'b0, "R5 write vs writer");
  endtask

  task automatic t_deny_no_state;
    do_req(0, 2, 1'b1, 1'b1, "R3 write free block");
    do_req(1, 2, 1'b0, 1'b0, "R4 read denied");
    release_one(0);
    // t1 took nothing on block 2, so a write by t3 must succeed
    do_req(3, 2, 1'b1, 1'b1, "R6 denied read left no token");
    do_req(0, 0, 1'b1, 1'b1, "R9 block 0 freed by release");
    release_one(3);
    release_one(0);
  endtask

  task automatic t_queued_release;
    int d0, d1;
    d0 = -1; d1 = -1;
    do_req(0, 5, 1'b1, 1'b1, "R3 t0 write b5");
    do_req(1, 7, 1'b0, 1'b1, "R2 t1 read b7");
    do_req(3, 6, 1'b1, 1'b1, "R3 t3 write b6");
    @(negedge clk);
    rel_req = 4'b0011;
    @(negedge clk);
    rel_req = '0;
    for (int k = 1; k <= 2*N_BLK + 4; k++) begin
      @(negedge clk);
      if (rel_done[0]) d0 = (d0 < 0) ? k : 100;
      if (rel_done[1]) d1 = (d1 < 0) ? k : 100;
    end
    chk(d0 == N_BLK + 1, "R10 lower thread first", d0, N_BLK + 1);
    chk(d1 == 2*N_BLK + 2, "R10 second release", d1, 2*N_BLK + 2);
    do_req(2, 5, 1'b1, 1'b1, "R9 b5 freed");
    do_req(2, 7, 1'b1, 1'b1, "R9 b7 freed");
    do_req(2, 6, 1'b1, 1'b0, "R9 other thread kept b6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_shared_reads;
    t_deny_no_state;
    t_queued_release;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule